// File: doc/BRIEF.md
# Configurable Decade Divider (BCD / Biquinary)

This block is one counting half of a decade divider, rebuilt for a single synchronous clock domain. It holds two count sections: a divide-by-two stage whose state appears on `q[0]`, and a divide-by-five stage whose state appears on `q[3:1]`. Each section has its own count strobe, `cnt_a_n` for the divide-by-two stage and `cnt_b_n` for the divide-by-five stage. A section advances when its strobe goes from high to low. Both strobes are registered on `clk` and searched for falling edges.

A two-bit `mode` input selects how the sections are wired. In independent mode each section counts only from its own strobe. In BCD mode `cnt_a_n` drives the divide-by-two stage, and each high-to-low step of `q[0]` carries into the divide-by-five stage, so `q` counts 0 to 9 in 8-4-2-1 code. In biquinary mode `cnt_b_n` drives the divide-by-five stage, and each wrap of that stage from 4 to 0 toggles `q[0]`. This gives a square wave on `q[0]` at one tenth of the input rate with 50% duty. The carry takes effect in the same clock cycle as the transition that causes it.

An active-high master clear `clr` and the system reset `rst_n` both zero the count and the edge-detector history. `mode` may change only while `clr` is high.

Top module: `decade_divider`

## Requirements
- R1: A section advances exactly once per high-to-low transition of its driving strobe. A rising strobe, or a strobe held steady at either level, leaves its state unchanged.
- R2: While `clr` is high, or `rst_n` is low, `q` is 0000 from the next clock edge onward and no strobe changes it.
- R3: The divide-by-five state on `q[3:1]` (`q[1]` least significant) steps 000, 001, 010, 011, 100 and then returns to 000. `q[3]` is high in one state of the five.
- R4: With `mode` = 2'b00 (2'b11 behaves the same), `q[0]` toggles only on falls of `cnt_a_n` and `q[3:1]` steps only on falls of `cnt_b_n`.
- R5: With `mode` = 2'b01, each fall of `cnt_a_n` moves `q` through 0 to 9 in 8-4-2-1 code and then back to 0. The divide-by-five stage advances in the same cycle that `q[0]` goes from 1 to 0.
- R6: With `mode` = 2'b10, each fall of `cnt_b_n` moves `q` through 0000, 0010, 0100, 0110, 1000, 0001, 0011, 0101, 0111, 1001 and back to 0000. `q[0]` is high for 5 of every 10 input falls.
- R7: In a cascaded mode the strobe of the downstream section (`cnt_b_n` in BCD, `cnt_a_n` in biquinary) has no effect on `q`.
- R8: A strobe held low across the release of `clr` produces no count when the clear ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr | input | 1 | Synchronous active-high master clear for both sections |
| mode | input | 2 | 00/11 independent, 01 BCD cascade, 10 biquinary cascade |
| cnt_a_n | input | 1 | Count strobe of the divide-by-two stage, counts on falling edge |
| cnt_b_n | input | 1 | Count strobe of the divide-by-five stage, counts on falling edge |
| q | output | 4 | Count state: q[0] divide-by-two, q[3:1] divide-by-five |

## Verification
The bench targets the wrap points. It checks BCD count 9 returning to 0, which a design with a missing or late carry would leave on 8 or push to 10. It checks the biquinary 9-to-0 step, where a design that toggles `q[0]` on the wrong divide-by-five state would break the 50% duty on `q[0]`. It holds a strobe low for several cycles and across the release of a clear, which catches a level-sensitive detector or history that is not cleared, since either one adds a spurious count. It also drives the downstream strobe in each cascaded mode, so any leak of that strobe shows up as an extra step on `q`.

// File: rtl/dd_pkg.sv
// Shared definitions for the decade divider: the wiring-mode encoding.
package dd_pkg;
    typedef enum logic [1:0] {
        MODE_INDEP  = 2'b00,
        MODE_BCD    = 2'b01,
        MODE_BIQ    = 2'b10,
        MODE_INDEP2 = 2'b11
    } dd_mode_e;
endpackage

// File: rtl/dd_fall_det.sv
// Falling-edge detector for one count strobe.
// Registers the strobe twice on clk. It reports a one-cycle pulse when the
// older sample is high and the newer one is low.
// Assumes: strobe is synchronous to clk. The history is cleared to low by
// reset or clear, so a strobe held low through reset gives no edge.
module dd_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe_n,
    output logic fall
);
    logic smp_now;
    logic smp_old;

    // Sample history of the strobe, forced low during reset/clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            smp_now <= 1'b0;
            smp_old <= 1'b0;
        end else begin
            smp_now <= strobe_n;
            smp_old <= smp_now;
        end
    end

    // High-then-low across two samples marks one edge.
    assign fall = smp_old & ~smp_now;

    // A detected edge lasts exactly one cycle (R1).
    p_fall_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/dd_modn.sv
// Modulo-MOD counter section that advances by one on each advance pulse.
// Reports when it sits on its final state, so a neighbour can use that as
// a carry. Assumes: advance is a single-cycle pulse in the clk domain.
module dd_modn #(
    parameter int MOD = 5,
    localparam int W = (MOD > 2) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         at_top
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    // Count state: clears on reset/clear, wraps after TOP.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (adv) begin
            count <= (count == TOP) ? '0 : count + 1'b1;
        end
    end

    // Final-state flag for the cascade carry.
    assign at_top = (count == TOP);

    // The state never leaves 0..MOD-1 (R3).
    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);
    // An advance from the final state returns to zero (R3).
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && count == TOP) |=> count == '0);
    // An advance from any other state adds one (R3).
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && count != TOP) |=> count == $past(count) + 1'b1);
    // Without an advance the state holds (R1).
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(count));
endmodule

// File: rtl/decade_divider.sv
// Decade divider half: a divide-by-two stage and a divide-by-five stage.
// Each stage has its own falling-edge count strobe. The mode input routes a
// same-cycle carry between the stages for the BCD or biquinary count.
// Assumes: mode changes only while clr is high. All inputs are synchronous
// to clk.
module decade_divider (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] mode,
    input  logic       cnt_a_n,
    input  logic       cnt_b_n,
    output logic [3:0] q
);
    import dd_pkg::*;

    localparam int LOW_MOD  = 2;
    localparam int HIGH_MOD = 5;
    localparam int HIGH_W   = $clog2(HIGH_MOD);

    dd_mode_e          mode_e;
    logic              fall_a;
    logic              fall_b;
    logic              adv_low;
    logic              adv_high;
    logic [0:0]        cnt_low;
    logic [HIGH_W-1:0] cnt_high;
    logic              top_low;
    logic              top_high;

    assign mode_e = dd_mode_e'(mode);

    dd_fall_det u_det_a (
        .clk(clk), .rst_n(rst_n), .clr(clr), .strobe_n(cnt_a_n), .fall(fall_a)
    );

    dd_fall_det u_det_b (
        .clk(clk), .rst_n(rst_n), .clr(clr), .strobe_n(cnt_b_n), .fall(fall_b)
    );

    // Advance routing: picks each stage's source from the wiring mode.
    always_comb begin
        case (mode_e)
            MODE_BCD: begin
                adv_low  = fall_a;
                adv_high = fall_a & top_low;
            end
            MODE_BIQ: begin
                adv_high = fall_b;
                adv_low  = fall_b & top_high;
            end
            default: begin
                adv_low  = fall_a;
                adv_high = fall_b;
            end
        endcase
    end

    dd_modn #(.MOD(LOW_MOD)) u_low (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv_low),
        .count(cnt_low), .at_top(top_low)
    );

    dd_modn #(.MOD(HIGH_MOD)) u_high (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv_high),
        .count(cnt_high), .at_top(top_high)
    );

    assign q = {cnt_high, cnt_low};

    // Clear zeroes the whole count on the next edge (R2).
    p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == 4'd0);
    // In BCD wiring the count never exceeds nine (R5).
    p_bcd_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_BCD) |-> q <= 4'd9);
    // In biquinary wiring a wrap of the high stage flips q[0] (R6).
    p_biq_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_BIQ && !clr && fall_b && q[3:1] == 3'b100)
        |=> q[0] != $past(q[0]));
    // In BCD wiring the high-stage strobe alone leaves q unchanged (R7).
    p_bcd_ignore_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_BCD && !clr && !fall_a) |=> $stable(q));
    // In biquinary wiring the low-stage strobe alone leaves q unchanged (R7).
    p_biq_ignore_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_BIQ && !clr && !fall_b) |=> $stable(q));
endmodule

// File: tb/decade_divider_tb.sv
// Scoreboard bench: driver tasks update a reference model and queue the
// expected count; a monitor pops and compares at the falling clock edge.
module decade_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cnt_a_n = 1'b1;
    logic       cnt_b_n = 1'b1;
    logic [3:0] q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    int m_low = 0;
    int m_high = 0;

    always #2 clk = ~clk;

    decade_divider u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode),
        .cnt_a_n(cnt_a_n), .cnt_b_n(cnt_b_n), .q(q)
    );

    // Monitor: compares queued expectations against q away from posedge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (q !== e) begin
                    failures++;
                    $display("FAIL %s: q=%b expected=%b", t, q, e);
                end
            end
        end
    end

    // Push the model state as the next expected result.
    task automatic expect_q(input string tag);
        @(posedge clk);
        exp_q.push_back(4'(m_high * 2 + m_low));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // One full low-then-high cycle on strobe A, with model update.
    task automatic pulse_a(input bit counts);
        @(negedge clk); cnt_a_n = 1'b0;
        repeat (3) @(negedge clk);
        cnt_a_n = 1'b1;
        repeat (3) @(negedge clk);
        if (counts && mode != 2'b10) begin
            if (mode == 2'b01 && m_low == 1) m_high = (m_high + 1) % 5;
            m_low = 1 - m_low;
        end
    endtask

    // One full low-then-high cycle on strobe B, with model update.
    task automatic pulse_b(input bit counts);
        @(negedge clk); cnt_b_n = 1'b0;
        repeat (3) @(negedge clk);
        cnt_b_n = 1'b1;
        repeat (3) @(negedge clk);
        if (counts && mode != 2'b01) begin
            if (mode == 2'b10 && m_high == 4) m_low = 1 - m_low;
            m_high = (m_high + 1) % 5;
        end
    endtask

    // Enter clear, pick a mode, leave clear; model goes to zero.
    task automatic reclear(input logic [1:0] m);
        @(negedge clk); clr = 1'b1; mode = m;
        repeat (2) @(negedge clk);
        clr = 1'b0;
        m_low = 0; m_high = 0;
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: timeout reached expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int highs;
        repeat (4) @(negedge clk);
        expect_q("R2 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_q("R2 after reset");

        // R4 / R1: independent mode, each stage from its own strobe.
        for (int i = 0; i < 3; i++) begin
            pulse_a(1'b1); expect_q("R4 indep strobe A");
        end
        for (int i = 0; i < 6; i++) begin
            pulse_b(1'b1); expect_q("R3 div5 sequence");
        end
        // R1: strobe held low for many cycles counts once.
        @(negedge clk); cnt_b_n = 1'b0;
        repeat (10) @(negedge clk);
        m_high = (m_high + 1) % 5;
        expect_q("R1 held low counts once");
        cnt_b_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_q("R1 rising edge no count");

        // R2: strobes during clear do nothing.
        @(negedge clk); clr = 1'b1;
        m_low = 0; m_high = 0;
        pulse_a(1'b0); pulse_b(1'b0);
        expect_q("R2 clear blocks counting");

        // R8: strobe A held low through release of clear.
        @(negedge clk); cnt_a_n = 1'b0;
        repeat (2) @(negedge clk);
        clr = 1'b0;
        repeat (4) @(negedge clk);
        expect_q("R8 no false edge on release");
        cnt_a_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_q("R8 no count on rise");

        // R5: BCD cascade through a full wrap.
        reclear(2'b01);
        for (int i = 0; i < 12; i++) begin
            pulse_a(1'b1); expect_q("R5 bcd count");
        end
        pulse_b(1'b1); expect_q("R7 bcd ignores strobe B");

        // R6: biquinary cascade, sequence and q[0] duty.
        reclear(2'b10);
        highs = 0;
        for (int i = 0; i < 10; i++) begin
            pulse_b(1'b1); expect_q("R6 biquinary count");
            if (q[0]) highs++;
        end
        checks++;
        if (highs != 5) begin
            failures++;
            $display("FAIL R6 duty: q0 high=%0d expected=5", highs);
        end
        pulse_b(1'b1); pulse_b(1'b1);
        expect_q("R6 biquinary continue");
        pulse_a(1'b1); expect_q("R7 biquinary ignores strobe A");

        // R4: mode 11 behaves as independent.
        reclear(2'b11);
        pulse_a(1'b1); pulse_b(1'b1);
        expect_q("R4 mode 11 independent");
        pulse_a(1'b1);
        expect_q("R4 mode 11 no carry");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule